// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Asymmetric Dead Time

This block converts a single direction bit into the four gate commands of a full bridge built from two legs, A and B. Each leg has an upper and a lower switch. For any output, switching on is held back by a programmable number of clock cycles, while switching off takes effect at the next clock edge. One delay setting serves both upper outputs and a separate setting serves both lower outputs. Because off is always faster than on, the two switches of one leg are never commanded on together.

Two overrides sit above the direction bit. A disable input forces all four outputs off and wins over every other input. A high-side enable input, when low, forces only the two upper outputs off while the lower pair keeps following the direction bit, so that load current freewheels through the lower switches (high-side chop). When disable is released, both lower outputs are driven on together for a fixed refresh window, so that the bootstrap capacitors of the upper drivers can recharge. The upper outputs stay blocked until a longer upper-enable window, also counted from the release, has run out. Either delay setting may be set to its all-ones value, which holds the outputs it governs off for as long as the value stays in place.

All inputs are expected to be synchronous to `clk`. The asynchronous active-low reset clears the block at once and is released in step with the clock.

Top module: `hbg_gate_seq`

## Requirements
- R1: With no override active and the sequencer running, direction 1 drives `a_hi_o` and `b_lo_o` high with `a_lo_o` and `b_hi_o` low; direction 0 drives `a_lo_o` and `b_hi_o` high with `a_hi_o` and `b_lo_o` low.
- R2: A `disable_i` of 1 sampled at a clock edge makes all four outputs 0 after that edge, whatever the other inputs are.
- R3: A `hi_en_i` of 0 sampled at an edge makes `a_hi_o` and `b_hi_o` 0 after that edge, while the lower outputs keep following the direction bit.
- R4: An upper output whose request becomes 1 at edge k rises after edge k+D, where D is `hi_dly_i` (0 to 254).
- R5: A lower output whose request becomes 1 at edge k rises after edge k+D, where D is `lo_dly_i`, independently of `hi_dly_i`.
- R6: An output whose request drops at an edge falls after that same edge with no added delay; `a_hi_o`/`a_lo_o` are never both 1, and the same holds for `b_hi_o`/`b_lo_o`.
- R7: A delay setting of 8'hFF keeps every output it governs that is currently 0 at 0; changing the setting to a finite value lets the pending request turn on.
- R8: If `disable_i` is first sampled 0 at edge E0, both lower outputs are 1 after edges E1 to E_REFRESH_CYC, after which the lower outputs follow the direction bit; no upper output is 1 before edge E(UPPER_EN_CYC+1), and an upper request turns on after edge E(UPPER_EN_CYC+1+`hi_dly_i`).
- R9: A request that is withdrawn before its turn-on delay has run out produces no pulse, and the next request starts a fresh full delay.
- R10: While `rst_n` is 0 all outputs are 0 immediately, and after reset the block sits in the disabled state until `disable_i` is sampled 0, which then starts the R8 sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dir_i | input | 1 | Bridge direction bit |
| disable_i | input | 1 | 1 forces all outputs off; release starts the refresh sequence |
| hi_en_i | input | 1 | 0 forces both upper outputs off (high-side chop) |
| hi_dly_i | input | DLY_W | Upper turn-on delay in cycles; all ones holds off |
| lo_dly_i | input | DLY_W | Lower turn-on delay in cycles; all ones holds off |
| a_hi_o | output | 1 | Leg A upper gate command |
| a_lo_o | output | 1 | Leg A lower gate command |
| b_hi_o | output | 1 | Leg B upper gate command |
| b_lo_o | output | 1 | Leg B lower gate command |

## Verification
The bench builds the block with REFRESH_CYC = 3 and UPPER_EN_CYC = 6 instead of the nanosecond-scale defaults, so the whole release sequence (refresh pulse end, upper hold-off and first delayed upper turn-on) fits in about ten cycles and every edge of it is checked exactly. Delay settings of 0, 1 to 4 and 8'hFF are applied at run time, which reaches the zero-delay swap, the off-by-one boundary of a withdrawn request, the independence of the two delay settings and the indefinite hold-off with its release.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // Sequencer phases after the block leaves the disabled state
  typedef enum logic [1:0] {
    PH_OFF     = 2'd0,
    PH_REFRESH = 2'd1,
    PH_UPWAIT  = 2'd2,
    PH_RUN     = 2'd3
  } phase_e;

  // Gate channel indexes; even indexes are upper switches
  localparam int unsigned CH_A_HI = 0;
  localparam int unsigned CH_A_LO = 1;
  localparam int unsigned CH_B_HI = 2;
  localparam int unsigned CH_B_LO = 3;
  localparam int unsigned CH_NUM  = 4;

endpackage

// File: rtl/hbg_rst_sync.sv
module hbg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= 2'b00;
    end else begin
      stg_q <= {stg_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stg_q[1];

endmodule

// File: rtl/hbg_phase_seq.sv
module hbg_phase_seq
  import hbg_pkg::*;
#(
  parameter int unsigned REFRESH_CYC  = 26,
  parameter int unsigned UPPER_EN_CYC = 34
) (
  input  logic clk,
  input  logic rst_n,
  input  logic disable_i,
  output logic refresh_o,
  output logic lo_allow_o,
  output logic hi_allow_o
);

  localparam int unsigned PH_W = $clog2(UPPER_EN_CYC + 1);
  localparam logic [PH_W-1:0] REF_LAST = PH_W'(REFRESH_CYC - 1);
  localparam logic [PH_W-1:0] UP_LAST  = PH_W'(UPPER_EN_CYC - 1);

  phase_e          st_q, st_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            ph_en;

  // Next-state logic
  always_comb begin
    st_d  = st_q;
    ph_d  = ph_q;
    ph_en = 1'b0;
    if (disable_i) begin
      st_d = PH_OFF;
    end else begin
      unique case (st_q)
        PH_OFF: begin
          st_d  = PH_REFRESH;
          ph_d  = '0;
          ph_en = 1'b1;
        end
        PH_REFRESH: begin
          ph_d  = ph_q + 1'b1;
          ph_en = 1'b1;
          if (ph_q == REF_LAST) st_d = PH_UPWAIT;
        end
        PH_UPWAIT: begin
          ph_d  = ph_q + 1'b1;
          ph_en = 1'b1;
          if (ph_q == UP_LAST) st_d = PH_RUN;
        end
        default: begin
          st_d = PH_RUN;
        end
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PH_OFF;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (ph_en) begin
      ph_q <= ph_d;
    end
  end

  assign refresh_o  = (st_q == PH_REFRESH) && !disable_i;
  assign lo_allow_o = ((st_q == PH_UPWAIT) || (st_q == PH_RUN)) && !disable_i;
  assign hi_allow_o = (st_q == PH_RUN) && !disable_i;

endmodule

// File: rtl/hbg_turnon_chan.sv
module hbg_turnon_chan #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             force_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             gate_o
);

  localparam logic [DLY_W-1:0] HOLD_OFF = {DLY_W{1'b1}};

  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             gate_q, gate_d;

  // Next-state logic: immediate off, counted on
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    gate_d = gate_q;
    if (force_i) begin
      gate_d = 1'b1;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (!req_i) begin
      gate_d = 1'b0;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (gate_q) begin
      gate_d = 1'b1;
    end else if (dly_i == HOLD_OFF) begin
      gate_d = 1'b0;
    end else if (cnt_q >= dly_i) begin
      gate_d = 1'b1;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate_d;
    end
  end

  assign gate_o = gate_q;

endmodule

// File: rtl/hbg_gate_seq.sv
module hbg_gate_seq
  import hbg_pkg::*;
#(
  parameter int unsigned DLY_W        = 8,
  parameter int unsigned REFRESH_CYC  = 26,
  parameter int unsigned UPPER_EN_CYC = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_i,
  input  logic             disable_i,
  input  logic             hi_en_i,
  input  logic [DLY_W-1:0] hi_dly_i,
  input  logic [DLY_W-1:0] lo_dly_i,
  output logic             a_hi_o,
  output logic             a_lo_o,
  output logic             b_hi_o,
  output logic             b_lo_o
);

  logic              rst_sync_n;
  logic              refresh;
  logic              lo_allow;
  logic              hi_allow;
  logic [CH_NUM-1:0] req;
  logic [CH_NUM-1:0] gate;

  hbg_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hbg_phase_seq #(
    .REFRESH_CYC  (REFRESH_CYC),
    .UPPER_EN_CYC (UPPER_EN_CYC)
  ) u_phase (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .disable_i  (disable_i),
    .refresh_o  (refresh),
    .lo_allow_o (lo_allow),
    .hi_allow_o (hi_allow)
  );

  // Requests per channel: direction 1 selects A-upper with B-lower
  always_comb begin
    req[CH_A_HI] = hi_allow && hi_en_i && dir_i;
    req[CH_B_HI] = hi_allow && hi_en_i && !dir_i;
    req[CH_A_LO] = lo_allow && !dir_i;
    req[CH_B_LO] = lo_allow && dir_i;
  end

  for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_chan
    if ((ch % 2) == 0) begin : g_upper
      hbg_turnon_chan #(.DLY_W(DLY_W)) u_chan (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .req_i   (req[ch]),
        .force_i (1'b0),
        .dly_i   (hi_dly_i),
        .gate_o  (gate[ch])
      );
    end else begin : g_lower
      hbg_turnon_chan #(.DLY_W(DLY_W)) u_chan (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .req_i   (req[ch]),
        .force_i (refresh),
        .dly_i   (lo_dly_i),
        .gate_o  (gate[ch])
      );
    end
  end

  assign a_hi_o = gate[CH_A_HI];
  assign a_lo_o = gate[CH_A_LO];
  assign b_hi_o = gate[CH_B_HI];
  assign b_lo_o = gate[CH_B_LO];

endmodule

// File: rtl/hbg_gate_seq_chk.sv
module hbg_gate_seq_chk #(
  parameter int unsigned DLY_W        = 8,
  parameter int unsigned UPPER_EN_CYC = 34
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dir_i,
  input logic             disable_i,
  input logic             hi_en_i,
  input logic [DLY_W-1:0] hi_dly_i,
  input logic [DLY_W-1:0] lo_dly_i,
  input logic             a_hi_o,
  input logic             a_lo_o,
  input logic             b_hi_o,
  input logic             b_lo_o
);

  localparam int unsigned     W_W = $clog2(UPPER_EN_CYC + 2);
  localparam logic [W_W-1:0]  W_LIM = W_W'(UPPER_EN_CYC + 1);
  localparam logic [DLY_W-1:0] HOLD = {DLY_W{1'b1}};

  // Cycles since disable was last seen high, saturating
  logic [W_W-1:0] rel_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q <= '0;
    end else if (disable_i) begin
      rel_q <= '0;
    end else if (rel_q != W_LIM) begin
      rel_q <= rel_q + 1'b1;
    end
  end

  p_leg_a_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_hi_o && a_lo_o));
  p_leg_b_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_hi_o && b_lo_o));
  p_disable_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    disable_i |=> !(a_hi_o || a_lo_o || b_hi_o || b_lo_o));
  p_chop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_en_i |=> !(a_hi_o || b_hi_o));
  p_a_hi_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_i |=> !a_hi_o);
  p_b_hi_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dir_i |=> !b_hi_o);
  p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_hi_o && hi_dly_i == HOLD) |=> !a_hi_o);
  p_hold_off_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_lo_o && !disable_i && lo_dly_i == HOLD && rel_q == W_LIM) |=> !a_lo_o);
  p_upper_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hi_o || b_hi_o) |-> (rel_q == W_LIM));

endmodule

bind hbg_gate_seq hbg_gate_seq_chk #(
  .DLY_W        (DLY_W),
  .UPPER_EN_CYC (UPPER_EN_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dir_i     (dir_i),
  .disable_i (disable_i),
  .hi_en_i   (hi_en_i),
  .hi_dly_i  (hi_dly_i),
  .lo_dly_i  (lo_dly_i),
  .a_hi_o    (a_hi_o),
  .a_lo_o    (a_lo_o),
  .b_hi_o    (b_hi_o),
  .b_lo_o    (b_lo_o)
);

// File: tb/tb_hbg_gate_seq.sv
module tb_hbg_gate_seq;

  localparam int unsigned DLY_W = 8;
  localparam int unsigned RCYC  = 3;
  localparam int unsigned UCYC  = 6;

  logic             clk;
  logic             rst_n;
  logic             dir_i, disable_i, hi_en_i;
  logic [DLY_W-1:0] hi_dly_i, lo_dly_i;
  logic             a_hi_o, a_lo_o, b_hi_o, b_lo_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  hbg_gate_seq #(
    .DLY_W        (DLY_W),
    .REFRESH_CYC  (RCYC),
    .UPPER_EN_CYC (UCYC)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_i     (dir_i),
    .disable_i (disable_i),
    .hi_en_i   (hi_en_i),
    .hi_dly_i  (hi_dly_i),
    .lo_dly_i  (lo_dly_i),
    .a_hi_o    (a_hi_o),
    .a_lo_o    (a_lo_o),
    .b_hi_o    (b_hi_o),
    .b_lo_o    (b_lo_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Row fields: [13] disable, [12] hi_en, [11] dir, [10:4] ticks, [3:0] {a_hi,a_lo,b_hi,b_lo}
  localparam int NV = 8;
  localparam logic [13:0] VEC [0:NV-1] = '{
    {1'b0, 1'b1, 1'b1, 7'd1,  4'b1001},  // R1 direction 1
    {1'b0, 1'b1, 1'b0, 7'd1,  4'b0110},  // R1 direction 0, zero-delay swap
    {1'b0, 1'b0, 1'b0, 7'd1,  4'b0100},  // R3 chop keeps A lower
    {1'b0, 1'b0, 1'b1, 7'd1,  4'b0001},  // R3 chop keeps B lower
    {1'b0, 1'b1, 1'b1, 7'd1,  4'b1001},  // R1 chop released
    {1'b1, 1'b1, 1'b1, 7'd1,  4'b0000},  // R2 disable
    {1'b1, 1'b0, 1'b0, 7'd1,  4'b0000},  // R2 disable wins over all
    {1'b0, 1'b1, 1'b0, 7'd10, 4'b0110}   // R8 release then run
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] got;
    got = {a_hi_o, a_lo_o, b_hi_o, b_lo_o};
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %b exp %b (a_hi a_lo b_hi b_lo)", tag, got, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; disable_i = 1'b1; hi_en_i = 1'b1; dir_i = 1'b1;
    hi_dly_i = 8'd2; lo_dly_i = 8'd1;
    repeat (3) tick();
    chk("R10 in reset", 4'b0000);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R10 disabled after reset", 4'b0000);

    // R8 release sequence, REFRESH 3, UPPER_EN 6, hi delay 2
    disable_i = 1'b0;
    tick(); chk("R8 E0", 4'b0000);
    tick(); chk("R8 E1 refresh", 4'b0101);
    tick(); chk("R8 E2 refresh", 4'b0101);
    tick(); chk("R8 E3 refresh", 4'b0101);
    tick(); chk("R8 E4 refresh end", 4'b0001);
    for (int i = 5; i <= 8; i++) begin
      tick(); chk("R8 upper held", 4'b0001);
    end
    tick(); chk("R4 R8 upper on E9", 4'b1001);

    // Vector table at zero delay
    hi_dly_i = 8'd0; lo_dly_i = 8'd0;
    for (int v = 0; v < NV; v++) begin
      disable_i = VEC[v][13];
      hi_en_i   = VEC[v][12];
      dir_i     = VEC[v][11];
      for (int t = 0; t < int'(VEC[v][10:4]); t++) tick();
      chk($sformatf("R1/R2/R3/R8 row %0d", v), VEC[v][3:0]);
    end

    // R9 short request with delay 3, R6 immediate turn-off
    hi_dly_i = 8'd3; lo_dly_i = 8'd3;
    dir_i = 1'b1;
    tick(); chk("R6 off at once", 4'b0000);
    tick(); chk("R9 counting", 4'b0000);
    dir_i = 1'b0;
    tick(); chk("R9 no short pulse", 4'b0000);
    tick(); chk("R9 fresh delay", 4'b0000);
    tick(); chk("R9 fresh delay", 4'b0000);
    tick(); chk("R4 R5 on after 3", 4'b0110);

    // R5 independent lower delay
    hi_dly_i = 8'd0; lo_dly_i = 8'd4;
    dir_i = 1'b1;
    tick(); chk("R5 upper first", 4'b1000);
    tick(); tick(); tick();
    chk("R5 lower still off", 4'b1000);
    tick(); chk("R5 lower on", 4'b1001);

    // R7 hold-off
    lo_dly_i = 8'hFF;
    dir_i = 1'b0;
    tick(); chk("R7 lower held", 4'b0010);
    repeat (20) tick();
    chk("R7 still held", 4'b0010);
    lo_dly_i = 8'd0;
    tick(); chk("R7 released", 4'b0110);

    // R3 chop in run
    hi_en_i = 1'b0;
    tick(); chk("R3 chop", 4'b0100);
    hi_en_i = 1'b1;
    tick(); chk("R3 chop end", 4'b0110);

    // R10 asynchronous reset
    rst_n = 1'b0;
    #1;
    chk("R10 async clear", 4'b0000);

    done = 1'b1;
    report();
  end

endmodule